// File: doc/BRIEF.md
# TFT Column Driver Line Loader

This block is the digital front end of a chainable TFT-LCD column driver. Every clock it accepts one 48-bit word carrying two RGB pixels (six 8-bit gray codes) and writes those codes into the next six-output group of a line register. The write position comes from a pointer that is armed by a start pulse and walks either to the right or to the left. Once the last group is written, the block raises a one-clock start pulse on the far-side pin, so the next driver in the chain begins loading.

A strobe, with one pulse per horizontal period, hands the line on to the drivers in two steps. On its rising edge the line register, the polarity select and the two inversion controls are captured into a hold stage. On its falling edge the hold stage is presented at the outputs. Each output carries an 8-bit gray code, a polarity flag and a reset (short) flag. Neighbouring pins always take opposite polarities. The two inversion controls complement the codes on the odd-numbered and the even-numbered pins separately. While the strobe is high and the reset mode is selected, every output is flagged as shorted.

Top module: `tft_line_loader`

## Requirements
- R1: A 48-bit word holds six 8-bit dots, with dot j in bits [8j+7:8j]. A line takes NUM_OUT/6 words, one per clock. The first word is written on the clock edge after the edge that samples the start pulse.
- R2: When shift_left is 0, the start pulse is taken from start_a_in. Word k, dot j is written to output index 6k+j (outputs numbered from index 0).
- R3: When shift_left is 1, the start pulse is taken from start_b_in. Word k, dot j is written to output index NUM_OUT-1-(6k+j).
- R4: After the last word has been written, the opposite pin (casc_b_out for right shift, casc_a_out for left shift) is high for exactly one clock, and the other cascade pin stays low.
- R5: A start pulse that arrives while a line is still loading is ignored. It changes neither the data placement nor the cascade timing.
- R6: A strobe rising edge captures the line. The outputs keep their previous values until the strobe falls, and they show the captured line from the first clock edge that sees the strobe low.
- R7: pol_flag bit i is the inverse of pol_sel for even i (odd-numbered pins) and equals pol_sel for odd i, both values taken at the strobe rising edge. Adjacent bits are therefore always opposite.
- R8: When inv_odd is 1 at the strobe rising edge, the codes of even-index outputs are bitwise complemented. inv_even does the same for odd-index outputs. With both at 0 the codes pass through unchanged. Changes to these inputs after the rising edge have no effect on the line being presented.
- R9: short_flag is all ones in the clock after an edge at which both rst_mode and strobe are 1, and all zeros after any edge at which rst_mode is 0 or strobe is 0.
- R10: After reset, gray_out is zero, pol_flag shows the pol_sel=0 pattern (bit 0 = 1), short_flag is zero and both cascade pins are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shift_left | input | 1 | 0 = right shift, 1 = left shift |
| start_a_in | input | 1 | Start pulse input for right shift |
| start_b_in | input | 1 | Start pulse input for left shift |
| casc_a_out | output | 1 | Cascade start pulse output for left shift |
| casc_b_out | output | 1 | Cascade start pulse output for right shift |
| pix_data | input | 48 | Two pixels, six 8-bit dots |
| strobe | input | 1 | Line strobe: capture on rise, present on fall |
| pol_sel | input | 1 | Polarity swap for odd and even pins |
| inv_odd | input | 1 | Complement codes of odd-numbered pins |
| inv_even | input | 1 | Complement codes of even-numbered pins |
| rst_mode | input | 1 | Enable output short while strobe is high |
| gray_out | output | NUM_OUT*8 | Gray code per output, index i at bits [8i+7:8i] |
| pol_flag | output | NUM_OUT | Polarity per output, 1 = positive ladder |
| short_flag | output | NUM_OUT | Output shorted (reset) flag |

## Verification
The assertions assume that shift_left stays steady from the start pulse to the last word, that the strobe is never raised while a line is loading, and that every start pulse lasts one clock or is held only within a load. The bench drives the strobe and start pulses only at falling clock edges, separates each load from the following strobe by idle cycles, and sweeps both directions together with every combination of polarity, both inversion controls and reset mode. Inversion and polarity inputs are flipped between the two strobe edges to show that only the rising-edge values count.

// File: rtl/tft_ll_pkg.sv
// Shared definitions for the TFT line loader.
// Assumes: nothing beyond IEEE 1800-2017.
package tft_ll_pkg;
    // Shift direction of the load pointer.
    typedef enum logic {
        SHIFT_RIGHT = 1'b0,
        SHIFT_LEFT  = 1'b1
    } shift_dir_e;

    // Width of a group index for a given group count (never zero).
    function automatic int idx_width(input int count);
        return (count > 1) ? $clog2(count) : 1;
    endfunction
endpackage

// File: rtl/tft_ll_shift_ctrl.sv
// Load pointer and start-pulse cascade.
// Starts on the pulse from the direction-selected pin, writes one group per
// clock for GROUPS clocks, then emits a one-clock pulse on the far-side pin.
// Assumes: shift_left is steady during a load; start pulses seen while a line
// is loading are ignored.
module tft_ll_shift_ctrl
    import tft_ll_pkg::*;
#(
    parameter int GROUPS = 64,
    parameter int GW     = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift_left,
    input  logic          start_a_in,
    input  logic          start_b_in,
    output logic          wr_en,
    output logic [GW-1:0] grp_idx,
    output logic          dir_q,
    output logic          casc_a_out,
    output logic          casc_b_out
);
    localparam logic [GW-1:0] LAST = GW'(GROUPS - 1);

    logic          running;
    logic [GW-1:0] cnt;
    logic          casc_q;
    logic          start_seen;

    // Pick the start pin that matches the requested direction.
    assign start_seen = (shift_dir_e'(shift_left) == SHIFT_LEFT) ? start_b_in : start_a_in;

    // Pointer sequencing: arm on start, advance per clock, stop after last group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            cnt     <= '0;
            casc_q  <= 1'b0;
            dir_q   <= 1'b0;
        end else begin
            casc_q <= 1'b0;
            if (running) begin
                if (cnt == LAST) begin
                    running <= 1'b0;
                    cnt     <= '0;
                    casc_q  <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else if (start_seen) begin
                running <= 1'b1;
                cnt     <= '0;
                dir_q   <= shift_left;
            end
        end
    end

    // Write group: counts up for right shift, down for left shift.
    assign wr_en   = running;
    assign grp_idx = dir_q ? (LAST - cnt) : cnt;

    // Cascade pulse leaves on the pin opposite the one that started the load.
    assign casc_a_out = casc_q & dir_q;
    assign casc_b_out = casc_q & ~dir_q;

    AST_CASCADE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (casc_a_out || casc_b_out) |=> !(casc_a_out || casc_b_out)); // R4
    AST_CASCADE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (running && cnt == LAST) |=> (casc_a_out || casc_b_out) && !running); // R4
    AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && start_seen) |=> running && cnt == '0); // R1
    AST_RESTART_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (running && cnt != LAST) |=> running && cnt == $past(cnt) + 1'b1); // R5
endmodule

// File: rtl/tft_ll_line_reg.sv
// Line register: holds one full line of gray codes, written one six-dot group
// at a time. In left shift the dot order inside a group is mirrored so the
// whole line fills from the far end.
// Assumes: grp_idx < GROUPS whenever wr_en is high.
module tft_ll_line_reg #(
    parameter int DW     = 8,
    parameter int DOTS   = 6,
    parameter int GROUPS = 64,
    parameter int GW     = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [GW-1:0]               grp_idx,
    input  logic                        dir_q,
    input  logic [DOTS*DW-1:0]          word_in,
    output logic [GROUPS*DOTS*DW-1:0]   line_flat
);
    localparam int WW = DOTS * DW;

    logic [WW-1:0]              wr_word;
    logic [GROUPS-1:0][WW-1:0]  row_q;

    // Mirror dot order for left shift, one slot per dot.
    for (genvar j = 0; j < DOTS; j++) begin : g_mirror
        assign wr_word[j*DW +: DW] = dir_q ? word_in[(DOTS-1-j)*DW +: DW]
                                           : word_in[j*DW +: DW];
    end

    // Group write into the addressed row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
        end else if (wr_en) begin
            for (int g = 0; g < GROUPS; g++) begin
                if (grp_idx == GW'(g)) row_q[g] <= wr_word;
            end
        end
    end

    assign line_flat = row_q;

    AST_LINE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(row_q)); // R1
    AST_GROUP_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> row_q[$past(grp_idx)] == $past(wr_word)); // R2
endmodule

// File: rtl/tft_ll_out_latch.sv
// Two-stage output latch. The strobe rising edge captures the line together
// with polarity and inversion settings; the falling edge presents the hold
// stage at the outputs. Also produces the output-short flag.
// Assumes: strobe is synchronous to clk and is not raised during a load.
module tft_ll_out_latch #(
    parameter int DW      = 8,
    parameter int NUM_OUT = 384
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    strobe,
    input  logic [NUM_OUT*DW-1:0]   line_flat,
    input  logic                    pol_sel,
    input  logic                    inv_odd,
    input  logic                    inv_even,
    input  logic                    rst_mode,
    output logic [NUM_OUT*DW-1:0]   gray_out,
    output logic [NUM_OUT-1:0]      pol_flag,
    output logic [NUM_OUT-1:0]      short_flag
);
    logic                          strobe_q;
    logic                          rise;
    logic                          fall;
    logic                          short_q;
    logic [NUM_OUT-1:0][DW-1:0]    hold_gray;
    logic [NUM_OUT-1:0]            hold_pol;
    logic [NUM_OUT-1:0][DW-1:0]    drv_gray;
    logic [NUM_OUT-1:0]            drv_pol;

    // Strobe edge tracking and short request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
            short_q  <= 1'b0;
        end else begin
            strobe_q <= strobe;
            short_q  <= rst_mode && strobe;
        end
    end

    assign rise = strobe && !strobe_q;
    assign fall = !strobe && strobe_q;

    // Hold capture on strobe rise, with per-parity inversion and polarity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int o = 0; o < NUM_OUT; o++) begin
                hold_gray[o] <= '0;
                hold_pol[o]  <= (o % 2 == 0);
            end
        end else if (rise) begin
            for (int o = 0; o < NUM_OUT; o++) begin
                hold_gray[o] <= line_flat[o*DW +: DW]
                                ^ {DW{(o % 2 == 0) ? inv_odd : inv_even}};
                hold_pol[o]  <= (o % 2 == 0) ? ~pol_sel : pol_sel;
            end
        end
    end

    // Drive update on strobe fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int o = 0; o < NUM_OUT; o++) begin
                drv_gray[o] <= '0;
                drv_pol[o]  <= (o % 2 == 0);
            end
        end else if (fall) begin
            drv_gray <= hold_gray;
            drv_pol  <= hold_pol;
        end
    end

    assign gray_out   = drv_gray;
    assign pol_flag   = drv_pol;
    assign short_flag = {NUM_OUT{short_q}};

    AST_DRIVE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !fall |=> $stable(drv_gray) && $stable(drv_pol)); // R6
    AST_NO_SHORT_MODE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_mode |=> short_flag == '0); // R9
    AST_SHORT_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_mode && strobe) |=> short_flag == '1); // R9

    if (NUM_OUT >= 2) begin : g_pol_chk
        AST_POL_OPPOSITE: assert property (@(posedge clk) disable iff (!rst_n)
            drv_pol[0] != drv_pol[1]); // R7
    end
endmodule

// File: rtl/tft_line_loader.sv
// Top of the TFT column driver line loader: load pointer, line register and
// output latch.
// Assumes: NUM_OUT is a multiple of DOTS_PER_WORD; inputs synchronous to clk.
module tft_line_loader
    import tft_ll_pkg::*;
#(
    parameter int DOT_W         = 8,
    parameter int DOTS_PER_WORD = 6,
    parameter int NUM_OUT       = 384
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        shift_left,
    input  logic                        start_a_in,
    input  logic                        start_b_in,
    output logic                        casc_a_out,
    output logic                        casc_b_out,
    input  logic [DOTS_PER_WORD*DOT_W-1:0] pix_data,
    input  logic                        strobe,
    input  logic                        pol_sel,
    input  logic                        inv_odd,
    input  logic                        inv_even,
    input  logic                        rst_mode,
    output logic [NUM_OUT*DOT_W-1:0]    gray_out,
    output logic [NUM_OUT-1:0]          pol_flag,
    output logic [NUM_OUT-1:0]          short_flag
);
    localparam int GROUPS = NUM_OUT / DOTS_PER_WORD;
    localparam int GW     = idx_width(GROUPS);

    logic                     wr_en;
    logic [GW-1:0]            grp_idx;
    logic                     dir_q;
    logic [NUM_OUT*DOT_W-1:0] line_flat;

    tft_ll_shift_ctrl #(
        .GROUPS (GROUPS),
        .GW     (GW)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_left (shift_left),
        .start_a_in (start_a_in),
        .start_b_in (start_b_in),
        .wr_en      (wr_en),
        .grp_idx    (grp_idx),
        .dir_q      (dir_q),
        .casc_a_out (casc_a_out),
        .casc_b_out (casc_b_out)
    );

    tft_ll_line_reg #(
        .DW     (DOT_W),
        .DOTS   (DOTS_PER_WORD),
        .GROUPS (GROUPS),
        .GW     (GW)
    ) u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .grp_idx   (grp_idx),
        .dir_q     (dir_q),
        .word_in   (pix_data),
        .line_flat (line_flat)
    );

    tft_ll_out_latch #(
        .DW      (DOT_W),
        .NUM_OUT (NUM_OUT)
    ) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe     (strobe),
        .line_flat  (line_flat),
        .pol_sel    (pol_sel),
        .inv_odd    (inv_odd),
        .inv_even   (inv_even),
        .rst_mode   (rst_mode),
        .gray_out   (gray_out),
        .pol_flag   (pol_flag),
        .short_flag (short_flag)
    );
endmodule

// File: tb/tft_line_loader_bench.sv
module tft_line_loader_bench;
    localparam int DW    = 8;
    localparam int DOTS  = 6;
    localparam int NOUT  = 24;
    localparam int LOADS = NOUT / DOTS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic shift_left = 1'b0, start_a_in = 1'b0, start_b_in = 1'b0;
    logic casc_a_out, casc_b_out;
    logic [DOTS*DW-1:0] pix_data = '0;
    logic strobe = 1'b0, pol_sel = 1'b0, inv_odd = 1'b0, inv_even = 1'b0, rst_mode = 1'b0;
    logic [NOUT*DW-1:0] gray_out;
    logic [NOUT-1:0] pol_flag, short_flag;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [DW-1:0] line_exp [NOUT];
    logic [DW-1:0] shown_g [NOUT];
    logic          shown_p [NOUT];

    always #2.5 clk = ~clk;

    tft_line_loader #(.DOT_W(DW), .DOTS_PER_WORD(DOTS), .NUM_OUT(NOUT)) u_tft_line_loader (
        .clk(clk), .rst_n(rst_n), .shift_left(shift_left),
        .start_a_in(start_a_in), .start_b_in(start_b_in),
        .casc_a_out(casc_a_out), .casc_b_out(casc_b_out),
        .pix_data(pix_data), .strobe(strobe), .pol_sel(pol_sel),
        .inv_odd(inv_odd), .inv_even(inv_even), .rst_mode(rst_mode),
        .gray_out(gray_out), .pol_flag(pol_flag), .short_flag(short_flag)
    );

    function automatic logic [DW-1:0] dot_val(input int t, input int k, input int j);
        return DW'((t * 37 + k * 6 + j * 11 + 5) & 255);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Compare all outputs with the shown_* model.
    task automatic check_outputs(input string req);
        bit ok = 1'b1;
        int bad = 0;
        for (int o = 0; o < NOUT; o++) begin
            if (gray_out[o*DW +: DW] !== shown_g[o] || pol_flag[o] !== shown_p[o]) begin
                if (ok) bad = o;
                ok = 1'b0;
            end
        end
        check(ok, req, $sformatf("output %0d gray/pol", bad),
              {gray_out[bad*DW +: DW], 7'b0, pol_flag[bad]},
              {shown_g[bad], 7'b0, shown_p[bad]});
    endtask

    // Load one line in direction dir; optionally send a spurious start mid-load.
    task automatic load_line(input int t, input bit dir, input bit extra);
        @(negedge clk);
        shift_left = dir;
        if (dir) start_b_in = 1'b1; else start_a_in = 1'b1;
        @(negedge clk);
        start_a_in = 1'b0; start_b_in = 1'b0;
        for (int k = 0; k < LOADS; k++) begin
            if (k > 0) @(negedge clk);
            for (int j = 0; j < DOTS; j++) pix_data[j*DW +: DW] = dot_val(t, k, j);
            if (extra && k == 1) begin
                if (dir) start_b_in = 1'b1; else start_a_in = 1'b1;
            end
            if (k == 2) begin start_a_in = 1'b0; start_b_in = 1'b0; end
        end
        for (int k = 0; k < LOADS; k++)
            for (int j = 0; j < DOTS; j++) begin
                int o = dir ? NOUT - 1 - (k * DOTS + j) : k * DOTS + j;
                line_exp[o] = dot_val(t, k, j);
            end
        @(negedge clk);
        start_a_in = 1'b0; start_b_in = 1'b0;
        // R4: pulse on far pin; R5 when extra start was sent
        check((dir ? casc_a_out : casc_b_out) === 1'b1 &&
              (dir ? casc_b_out : casc_a_out) === 1'b0,
              extra ? "R4/R5" : "R4", "cascade high after last word",
              {casc_a_out, casc_b_out}, dir ? 2'b10 : 2'b01);
        @(negedge clk);
        check(casc_a_out === 1'b0 && casc_b_out === 1'b0, "R4", "cascade one clock",
              {casc_a_out, casc_b_out}, 0);
        @(negedge clk);
    endtask

    // Strobe the line out with given settings; flip settings between edges.
    task automatic strobe_line(input bit ps, input bit io, input bit ie, input bit rm);
        @(negedge clk);
        strobe = 1'b1; pol_sel = ps; inv_odd = io; inv_even = ie; rst_mode = rm;
        @(negedge clk);
        check(short_flag === {NOUT{rm}}, "R9", "short while strobe high",
              short_flag, {NOUT{rm}});
        check_outputs("R6 stale before fall");
        pol_sel = ~ps; inv_odd = ~io; inv_even = ~ie;
        strobe = 1'b0;
        @(negedge clk);
        for (int o = 0; o < NOUT; o++) begin
            bit odd_pin = (o % 2 == 0);
            shown_g[o] = line_exp[o] ^ {DW{odd_pin ? io : ie}};
            shown_p[o] = odd_pin ? ~ps : ps;
        end
        check_outputs("R2/R3/R6/R7/R8 presented line");
        check(short_flag === '0, "R9", "short clear after strobe low", short_flag, 0);
        rst_mode = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        for (int o = 0; o < NOUT; o++) begin
            shown_g[o] = '0;
            shown_p[o] = (o % 2 == 0);
            line_exp[o] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check_outputs("R10 reset outputs");
        check(short_flag === '0 && casc_a_out === 1'b0 && casc_b_out === 1'b0,
              "R10", "reset flags", {short_flag, casc_a_out, casc_b_out}, 0);
        // R1 R2 R3 R7 R8 R9 sweep
        for (int cfg = 0; cfg < 32; cfg++) begin
            bit dir = cfg[0];
            load_line(cfg, dir, cfg[4]);
            strobe_line(cfg[1], cfg[2], cfg[3], cfg[4] ^ cfg[0]);
        end
        // R8: both inversions low, right shift, plain mapping
        load_line(99, 1'b0, 1'b0);
        strobe_line(1'b0, 1'b0, 1'b0, 1'b1);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule